// File: doc/BRIEF.md
# Presettable Decade Counter Digit

This block is one decimal digit of a synchronous counter. Its 4-bit state runs through the values 0 to 9 on rising clock edges and returns to 0 after 9. A 4-bit value can be preset on a clock edge, and a low level on the clear input empties the digit at once, without waiting for the clock.

Counting needs two enables. One is a plain enable. The other, the chain enable, also qualifies the terminal-count output. That output is high only while the digit shows nine and the chain enable is high. To build a multi-digit counter, drive the chain enable of each more significant digit from the terminal-count output of the digit below it, and tie its plain enable high or share it. The terminal-count output is combinational, so the next digit sees it in the same cycle that the lower digit reaches nine.

All pins are plain control and status lines. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `decade_digit_counter`

## Requirements
- R1: While clear_n is low, q is 0000 at once, before any clock edge and whatever the levels of load_n, cep, cet and d.
- R2: When load_n is low at a rising edge (clear_n high), q takes the value of d on that edge, whatever the levels of cep and cet.
- R3: When clear_n, load_n, cep and cet are all high at a rising edge and q is below 9, q increases by one on that edge.
- R4: When load_n is high and cep or cet is low at a rising edge, q keeps its value.
- R5: tc is high exactly when cet is high and q equals 9 (binary 1001). It follows a change of cet in the same cycle, with no register in the path.
- R6: A counting edge taken while q is 9 sets q to 0.
- R7: After a load of a value from 10 to 15, the next counting edge sets q to 0. While q holds such a value, tc is low even with cet high.
- R8: Two digits chained (the low digit's tc driving the high digit's cet, the high digit's cep tied high) count 00 to 99 in order and roll over from 99 to 00. On the 99 to 00 edge the high digit's tc is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on its rising edge |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset, active low; takes priority over counting |
| cep | input | 1 | Plain count enable, active high |
| cet | input | 1 | Chain count enable, active high; also qualifies tc |
| d | input | 4 | Value to preset |
| q | output | 4 | Present count |
| tc | output | 1 | Terminal count: cet high and q equal to 9 |

## Verification
A load, a count step or a hold shows on q one rising edge after the inputs are applied. The bench therefore changes the inputs on a falling edge and reads q on the next falling edge, half a period after the rising edge that should have changed it. tc has no register, and clear acts without the clock, so both are checked one time unit after the input that changes them, with no clock edge in between. The chained roll-over compares both digits against a two-digit decimal model after every one of 100 edges.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int DIGIT_W  = 4;
  localparam int TERM_VAL = 9;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } op_e;
endpackage

// File: rtl/dcd_ctrl.sv
// Picks the operation for the next edge: load first, then count, else hold.
module dcd_ctrl
  import dcd_pkg::*;
(
  input  logic load_n,
  input  logic cep,
  input  logic cet,
  output op_e  op
);
  always_comb begin
    if (!load_n)          op = OP_LOAD;
    else if (cep && cet)  op = OP_STEP;
    else                  op = OP_HOLD;
  end
endmodule

// File: rtl/dcd_next.sv
// Next-state value of one digit.
module dcd_next
  import dcd_pkg::*;
#(
  parameter int W    = 4,
  parameter int TERM = 9
) (
  input  op_e          op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] TERM_Q = W'(TERM);

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = din;
      OP_STEP: nxt = (cur >= TERM_Q) ? '0 : cur + W'(1);
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dcd_term.sv
// Terminal-count detect, qualified by the chain enable.
module dcd_term #(
  parameter int W    = 4,
  parameter int TERM = 9
) (
  input  logic         cet,
  input  logic [W-1:0] cur,
  output logic         tc
);
  localparam logic [W-1:0] TERM_Q = W'(TERM);

  assign tc = cet & (cur == TERM_Q);
endmodule

// File: rtl/decade_digit_counter.sv
module decade_digit_counter
  import dcd_pkg::*;
#(
  parameter int DIGIT_W_P  = DIGIT_W,
  parameter int TERM_VAL_P = TERM_VAL
) (
  input  logic                 clk,
  input  logic                 clear_n,
  input  logic                 load_n,
  input  logic                 cep,
  input  logic                 cet,
  input  logic [DIGIT_W_P-1:0] d,
  output logic [DIGIT_W_P-1:0] q,
  output logic                 tc
);
  localparam logic [DIGIT_W_P-1:0] TERM_Q = DIGIT_W_P'(TERM_VAL_P);

  op_e                  op;
  logic [DIGIT_W_P-1:0] q_nxt;
  logic [DIGIT_W_P-1:0] q_r;

  dcd_ctrl u_ctrl (
    .load_n (load_n),
    .cep    (cep),
    .cet    (cet),
    .op     (op)
  );

  dcd_next #(.W(DIGIT_W_P), .TERM(TERM_VAL_P)) u_next (
    .op  (op),
    .cur (q_r),
    .din (d),
    .nxt (q_nxt)
  );

  dcd_term #(.W(DIGIT_W_P), .TERM(TERM_VAL_P)) u_term (
    .cet (cet),
    .cur (q_r),
    .tc  (tc)
  );

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) q_r <= '0;
    else          q_r <= q_nxt;
  end

  assign q = q_r;

  // R1: q is empty at every edge seen while clear is held
  p_clear_empty_r1: assert property (@(posedge clk)
    !clear_n |-> q == '0);

  p_load_copies_r2: assert property (@(posedge clk) disable iff (!clear_n)
    !load_n |=> q == $past(d));

  p_step_inc_r3: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && cep && cet && q < TERM_Q) |=> q == $past(q) + DIGIT_W_P'(1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !(cep && cet)) |=> $stable(q));

  p_tc_r5: assert property (@(posedge clk) disable iff (!clear_n)
    tc == (cet && q == TERM_Q));

  // R6 and R7: a step from nine or from any value above it lands on zero
  p_wrap_r6: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && cep && cet && q >= TERM_Q) |=> q == '0);
endmodule

// File: tb/decade_digit_counter_tb.sv
module decade_digit_counter_tb;
  logic       clk = 1'b0;
  logic       clear_n, load_n, cep, cet;
  logic [3:0] d, d_hi;
  logic [3:0] q, q_hi;
  logic       tc, tc_hi;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  decade_digit_counter u_dut (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .cep(cep), .cet(cet),
    .d(d), .q(q), .tc(tc)
  );

  decade_digit_counter u_dut_hi (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .cep(1'b1), .cet(tc),
    .d(d_hi), .q(q_hi), .tc(tc_hi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one rising edge, then land on the following falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic ld, input logic p, input logic t, input logic [3:0] v);
    load_n = ld; cep = p; cet = t; d = v;
  endtask

  task automatic t_reset();
    chk(q == 4'd0, "R1 reset q", q, 0);
    chk(q_hi == 4'd0, "R1 reset q_hi", q_hi, 0);
    chk(tc == 1'b0, "R5 reset tc", tc, 0);
  endtask

  task automatic t_load_any_enables();
    drive(1'b0, 1'b0, 1'b0, 4'd3); tick();
    chk(q == 4'd3, "R2 load enables low", q, 3);
    drive(1'b0, 1'b1, 1'b1, 4'd6); tick();
    chk(q == 4'd6, "R2 load enables high", q, 6);
  endtask

  task automatic t_sequence();
    int exp_seq[6] = '{8, 9, 0, 1, 2, 3};
    drive(1'b0, 1'b0, 1'b0, 4'd7); tick();
    chk(q == 4'd7, "R2 load seven", q, 7);
    drive(1'b1, 1'b1, 1'b1, 4'd0);
    foreach (exp_seq[i]) begin
      tick();
      chk(q == 4'(exp_seq[i]), (exp_seq[i] == 0) ? "R6 wrap" : "R3 step", q, exp_seq[i]);
    end
    cep = 1'b0; tick();
    chk(q == 4'd3, "R4 hold cep low", q, 3);
    cep = 1'b1; cet = 1'b0; tick();
    chk(q == 4'd3, "R4 hold cet low", q, 3);
  endtask

  task automatic t_tc();
    drive(1'b0, 1'b0, 1'b1, 4'd9); tick();
    load_n = 1'b1; cep = 1'b0;
    #1 chk(tc == 1'b1, "R5 tc at nine", tc, 1);
    cet = 1'b0;
    #1 chk(tc == 1'b0, "R5 tc follows cet", tc, 0);
    cet = 1'b1;
    #1 chk(tc == 1'b1, "R5 tc back", tc, 1);
    drive(1'b0, 1'b0, 1'b1, 4'd8); tick();
    chk(tc == 1'b0, "R5 tc at eight", tc, 0);
  endtask

  task automatic t_above_nine();
    drive(1'b0, 1'b0, 1'b1, 4'd12); tick();
    chk(q == 4'd12, "R7 load twelve", q, 12);
    chk(tc == 1'b0, "R7 tc low at twelve", tc, 0);
    drive(1'b1, 1'b1, 1'b1, 4'd0); tick();
    chk(q == 4'd0, "R7 step from twelve", q, 0);
    drive(1'b0, 1'b0, 1'b0, 4'd15); tick();
    cet = 1'b1; #1 chk(tc == 1'b0, "R7 tc low at fifteen", tc, 0);
    drive(1'b1, 1'b1, 1'b1, 4'd0); tick();
    chk(q == 4'd0, "R7 step from fifteen", q, 0);
  endtask

  task automatic t_async_clear();
    drive(1'b0, 1'b1, 1'b1, 4'd5); tick();
    load_n = 1'b0; d = 4'd4;
    #1 clear_n = 1'b0;
    #1 chk(q == 4'd0, "R1 clear without edge", q, 0);
    @(negedge clk);
    clear_n = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_cascade();
    int ref_cnt = 0;
    clear_n = 1'b0; #1 clear_n = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 4'd0); d_hi = 4'd0;
    for (int s = 0; s < 100; s++) begin
      bit hi_tc_seen;
      #1 hi_tc_seen = tc_hi;
      if (ref_cnt == 99)
        chk(hi_tc_seen == 1'b1, "R8 tc_hi at 99", hi_tc_seen, 1);
      tick();
      ref_cnt = (ref_cnt + 1) % 100;
      chk(q == 4'(ref_cnt % 10) && q_hi == 4'(ref_cnt / 10), "R8 chained count",
          int'(q_hi) * 10 + int'(q), ref_cnt);
    end
    chk(q == 4'd0 && q_hi == 4'd0, "R8 roll-over to 00", int'(q_hi) * 10 + int'(q), 0);
  endtask

  initial begin
    clear_n = 1'b1; load_n = 1'b1; cep = 1'b0; cet = 1'b0; d = '0; d_hi = '0;
    #1 clear_n = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    clear_n = 1'b1;
    t_load_any_enables();
    t_sequence();
    t_tc();
    t_above_nine();
    t_async_clear();
    t_cascade();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 5000, 0);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule